// File: doc/BRIEF.md
# Load/Store Data Width Formatter

This block sits between a 32-bit register file and a byte-addressed memory port and shapes the data that moves between them. On the load side it takes a value read from memory, or copied from another register, keeps 8, 16 or 32 bits of it and widens the result back to a full register with zeros or with copies of the field's top bit. It also places a 16-bit immediate into either half of a destination register. With the upper placement the lower half of the old register value is kept, so a full 32-bit constant takes two immediate operations.

On the store side it splits a register value into big-endian byte lanes with a matching byte-enable mask. Lane 0 is the base address. A store has no signedness. Every result is registered once, so it appears one clock after the request. Address generation, decode and the memory are outside the block.

Top module: `ldst_fmt`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises with no request, `wb_valid`, `st_valid`, `wb_data`, `st_data` and `st_be` are all zero.
- R2: A request (`in_valid`=1) produces its result on the outputs exactly one clock later. `in_op` 2'b00 (load) and 2'b01 (immediate) raise only `wb_valid`, 2'b10 (store) raises only `st_valid`, and 2'b11 or `in_valid`=0 raises neither. `st_be` is zero whenever `st_valid` is low.
- R3: A load with `in_signed`=0 and `in_size` 2'b00 (8 bits) or 2'b01 (16 bits) copies that many low bits of `in_src` into `wb_data` and clears all higher bits.
- R4: A load with `in_signed`=1 and `in_size`=2'b01 copies `in_src[15:0]` and fills `wb_data[31:16]` with `in_src[15]`.
- R5: A load with `in_signed`=1 and `in_size`=2'b00 copies `in_src[7:0]` and fills `wb_data[31:8]` with `in_src[7]`.
- R6: A load with `in_size`=2'b10 (32 bits) returns `in_src` unchanged for either value of `in_signed`.
- R7: An immediate with `in_imm_hi`=0 gives `wb_data[15:0]`=`in_imm` and `wb_data[31:16]`=0.
- R8: An immediate with `in_imm_hi`=1 gives `wb_data[31:16]`=`in_imm` and `wb_data[15:0]`=`in_dest_old[15:0]`.
- R9: A 32-bit store (`in_size`=2'b10) gives `st_be`=4'b1111, with lane k (`st_data[31-8k -: 8]`, address base+k) holding `in_src[31-8k -: 8]`, so base gets bits 31:24 and base+3 gets bits 7:0.
- R10: A 16-bit store gives `st_be`=4'b0011, lane 0 = `in_src[15:8]`, lane 1 = `in_src[7:0]`, and lanes 2 and 3 zero.
- R11: An 8-bit store gives `st_be`=4'b0001, lane 0 = `in_src[7:0]`, and the other lanes zero.
- R12: `in_signed` has no effect on a store: `st_data` and `st_be` are the same for both values.
- R13: `in_size`=2'b11 acts as the 32-bit width for both loads and stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | 00 load, 01 immediate, 10 store, 11 idle |
| in_size | input | 2 | 00 8-bit, 01 16-bit, 10/11 32-bit |
| in_signed | input | 1 | 1 = sign-extend a narrow load |
| in_imm_hi | input | 1 | 1 = place the immediate in the upper half |
| in_imm | input | 16 | Immediate value |
| in_src | input | 32 | Memory read data, or source register for a load or store |
| in_dest_old | input | 32 | Current destination register value |
| wb_valid | output | 1 | Writeback result valid |
| wb_data | output | 32 | Writeback result |
| st_valid | output | 1 | Store lanes valid |
| st_data | output | 32 | Store bytes, lane 0 in bits 31:24 |
| st_be | output | 4 | Byte enable per lane, bit k = base+k |

## Verification
The bench builds the block with its defaults, a 32-bit data path and 8-bit bytes, so there are four lanes and a 16-bit immediate. With these values every combination of operation, size code, signedness and half select is swept. Each combination is run over boundary values that sit on either side of bits 7, 15 and 31, and over a pseudo-random set. This covers both fill values of every extension, every lane position of every store width and the reserved size code. The idle operation and dropped strobes are checked between requests.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_IMM   = 2'b01,
    OP_STORE = 2'b10,
    OP_IDLE  = 2'b11
  } fmt_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } fmt_size_e;

  // number of byte lanes a size code covers, full width for the two top codes
  function automatic int unsigned size_lanes(fmt_size_e sz, int unsigned nlanes);
    case (sz)
      SZ_BYTE: size_lanes = 1;
      SZ_HALF: size_lanes = 2;
      default: size_lanes = nlanes;
    endcase
  endfunction

endpackage

// File: rtl/ldfmt_extend.sv
module ldfmt_extend
  import ldfmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src,
  input  fmt_size_e         size,
  input  logic              sgn,
  output logic [DATA_W-1:0] res
);
  localparam int NLANES = DATA_W / BYTE_W;

  // keep nbits of v, fill the rest with zero or the field's top bit
  function automatic logic [DATA_W-1:0] trim_extend(logic [DATA_W-1:0] v,
                                                    int unsigned nbits, logic s);
    logic [DATA_W-1:0] r;
    logic fill;
    fill = s & v[nbits-1];
    for (int i = 0; i < DATA_W; i++) begin
      r[i] = (i < nbits) ? v[i] : fill;
    end
    return r;
  endfunction

  int unsigned field_bits;
  logic        narrow;
  logic        fill_bit;

  always_comb begin
    field_bits = size_lanes(size, NLANES) * BYTE_W;
    narrow     = (field_bits < DATA_W);
    fill_bit   = sgn & src[field_bits-1];
    res        = trim_extend(src, field_bits, sgn);
  end

  AST_UNSIGNED_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow && !sgn) |-> (res[DATA_W-1] == 1'b0)); // R3

  AST_SIGNED_TOP_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow && sgn) |-> (res[DATA_W-1] == src[field_bits-1])); // R4

  AST_FULL_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (!narrow) |-> (res == src)); // R6

endmodule

// File: rtl/ldfmt_imm.sv
module ldfmt_imm #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W/2-1:0] imm,
  input  logic                hi,
  input  logic [DATA_W-1:0]   old,
  output logic [DATA_W-1:0]   res
);
  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] place_half(logic [HALF_W-1:0] v, logic upper,
                                                   logic [DATA_W-1:0] prev);
    if (upper) return {v, prev[HALF_W-1:0]};
    return {{HALF_W{1'b0}}, v};
  endfunction

  always_comb res = place_half(imm, hi, old);

  AST_HI_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hi |-> (res[HALF_W-1:0] == old[HALF_W-1:0])); // R8

  AST_LO_CLEARS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !hi |-> (res[DATA_W-1:HALF_W] == '0)); // R7

endmodule

// File: rtl/ldfmt_store.sv
module ldfmt_store
  import ldfmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DATA_W-1:0]        src,
  input  fmt_size_e                size,
  output logic [DATA_W-1:0]        lanes,
  output logic [DATA_W/BYTE_W-1:0] be
);
  localparam int NLANES = DATA_W / BYTE_W;

  // byte of v that lands in lane k when n lanes are written, high byte first
  function automatic logic [BYTE_W-1:0] lane_byte(logic [DATA_W-1:0] v,
                                                  int unsigned n, int unsigned k);
    if (k >= n) return '0;
    return v[(n-1-k)*BYTE_W +: BYTE_W];
  endfunction

  int unsigned nwrite;
  always_comb nwrite = size_lanes(size, NLANES);

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    // lane k sits at the top of the bus for k = 0 (big-endian)
    always_comb begin
      lanes[DATA_W-1-k*BYTE_W -: BYTE_W] = lane_byte(src, nwrite, k);
      be[k] = (k < nwrite);
    end
  end

  AST_BE_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (be[0] && ((be & (be + 1'b1)) == '0))); // R9

  AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(be) == nwrite)); // R10

  AST_LAST_LANE_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (lanes[DATA_W-1-(nwrite-1)*BYTE_W -: BYTE_W] == src[BYTE_W-1:0])); // R11

endmodule

// File: rtl/ldst_fmt.sv
module ldst_fmt
  import ldfmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [1:0]               in_op,
  input  logic [1:0]               in_size,
  input  logic                     in_signed,
  input  logic                     in_imm_hi,
  input  logic [DATA_W/2-1:0]      in_imm,
  input  logic [DATA_W-1:0]        in_src,
  input  logic [DATA_W-1:0]        in_dest_old,
  output logic                     wb_valid,
  output logic [DATA_W-1:0]        wb_data,
  output logic                     st_valid,
  output logic [DATA_W-1:0]        st_data,
  output logic [DATA_W/BYTE_W-1:0] st_be
);
  localparam int NLANES = DATA_W / BYTE_W;
  localparam int HALF_W = DATA_W / 2;

  fmt_op_e   op;
  fmt_size_e sz;
  always_comb begin
    op = fmt_op_e'(in_op);
    sz = fmt_size_e'(in_size);
  end

  // named request events
  logic req_load, req_imm, req_store, req_wb;
  always_comb begin
    req_load  = in_valid && (op == OP_LOAD);
    req_imm   = in_valid && (op == OP_IMM);
    req_store = in_valid && (op == OP_STORE);
    req_wb    = req_load || req_imm;
  end

  logic [DATA_W-1:0] ext_res, imm_res, st_lanes;
  logic [NLANES-1:0] st_mask;

  ldfmt_extend #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_extend (
    .clk(clk), .rst_n(rst_n), .src(in_src), .size(sz), .sgn(in_signed), .res(ext_res)
  );

  ldfmt_imm #(.DATA_W(DATA_W)) u_imm (
    .clk(clk), .rst_n(rst_n), .imm(in_imm), .hi(in_imm_hi), .old(in_dest_old),
    .res(imm_res)
  );

  ldfmt_store #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .src(in_src), .size(sz), .lanes(st_lanes), .be(st_mask)
  );

  logic [DATA_W-1:0] wb_next;
  always_comb wb_next = req_imm ? imm_res : ext_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_data  <= '0;
      st_valid <= 1'b0;
      st_data  <= '0;
      st_be    <= '0;
    end else begin
      wb_valid <= req_wb;
      st_valid <= req_store;
      st_be    <= req_store ? st_mask : '0;
      if (req_wb)    wb_data <= wb_next;
      if (req_store) st_data <= st_lanes;
    end
  end

  AST_ONE_RESULT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_valid && st_valid)); // R2

  AST_IDLE_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |-> (st_be == '0)); // R2

  AST_STORE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b10) |=> (st_valid && st_be[0])); // R2

  AST_IMM_HI_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b01 && in_imm_hi) |=>
      (wb_data == {$past(in_imm), $past(in_dest_old[HALF_W-1:0])})); // R8

  AST_BYTE_SIGNED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b00 && in_size == 2'b00 && in_signed) |=>
      (wb_data == {{(DATA_W-BYTE_W){$past(in_src[BYTE_W-1])}}, $past(in_src[BYTE_W-1:0])})); // R5

  AST_RSVD_SIZE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b10 && in_size == 2'b11) |=> (st_be == '1)); // R13

endmodule

// File: tb/tb_ldst_fmt.sv
`timescale 1ns/1ps
module tb_ldst_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'b11;
  logic [1:0]  in_size = 2'b00;
  logic        in_signed = 1'b0;
  logic        in_imm_hi = 1'b0;
  logic [15:0] in_imm = '0;
  logic [31:0] in_src = '0;
  logic [31:0] in_dest_old = '0;
  logic        wb_valid, st_valid;
  logic [31:0] wb_data, st_data;
  logic [3:0]  st_be;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ldst_fmt dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_size(in_size),
    .in_signed(in_signed), .in_imm_hi(in_imm_hi), .in_imm(in_imm), .in_src(in_src),
    .in_dest_old(in_dest_old), .wb_valid(wb_valid), .wb_data(wb_data),
    .st_valid(st_valid), .st_data(st_data), .st_be(st_be)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int unsigned width_bits(logic [1:0] sz);
    return (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
  endfunction

  // arithmetic model of a load: remainder modulo 2^n, then shift up by 2^32-2^n if negative
  function automatic logic [31:0] exp_load(logic [31:0] v, logic [1:0] sz, logic s);
    longint unsigned n, lo;
    n = width_bits(sz);
    if (n == 32) return v;
    lo = longint'(v) % (64'd1 << n);
    if (s && lo >= (64'd1 << (n - 1))) lo = lo + (64'd1 << 32) - (64'd1 << n);
    return lo[31:0];
  endfunction

  function automatic logic [31:0] exp_store(logic [31:0] v, logic [1:0] sz);
    logic [31:0] r;
    int unsigned n;
    n = width_bits(sz) / 8;
    r = '0;
    for (int k = 0; k < 4; k++)
      if (k < n) r = r | (((v >> (8 * (n - 1 - k))) & 32'hFF) << (24 - 8 * k));
    return r;
  endfunction

  task automatic issue(logic [1:0] op, logic [1:0] sz, logic s, logic hi,
                       logic [15:0] imm, logic [31:0] src, logic [31:0] old);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_size = sz; in_signed = s; in_imm_hi = hi;
    in_imm = imm; in_src = src; in_dest_old = old;
    @(negedge clk);
  endtask

  task automatic idle_check(logic vld, logic [1:0] op);
    @(negedge clk);
    in_valid = vld; in_op = op;
    @(negedge clk);
    check("R2 idle wb_valid", 64'(wb_valid), 64'd0);
    check("R2 idle st_valid", 64'(st_valid), 64'd0);
    check("R2 idle st_be", 64'(st_be), 64'd0);
  endtask

  logic [31:0] pats [0:39];

  initial begin
    logic [31:0] lf;
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h0000_007F;
    pats[3] = 32'h0000_0080; pats[4] = 32'h0000_00FF; pats[5] = 32'h0000_7FFF;
    pats[6] = 32'h0000_8000; pats[7] = 32'h8000_0000; pats[8] = 32'h7FFF_FFFF;
    pats[9] = 32'h1234_5678; pats[10] = 32'h89AB_CDEF; pats[11] = 32'hFFFF_FF7F;
    pats[12] = 32'hFFFF_7F80; pats[13] = 32'h0102_0304; pats[14] = 32'hA5A5_5A5A;
    pats[15] = 32'h00FF_8001;
    lf = 32'hACE1_2468;
    for (int i = 16; i < 40; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      pats[i] = lf * 32'd2654435761;
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 wb_valid", 64'(wb_valid), 0); check("R1 st_valid", 64'(st_valid), 0);
    check("R1 wb_data", 64'(wb_data), 0); check("R1 st_data", 64'(st_data), 0);
    check("R1 st_be", 64'(st_be), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release wb_valid", 64'(wb_valid), 0);
    check("R1 after release st_be", 64'(st_be), 0);

    for (int p = 0; p < 40; p++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int s = 0; s < 2; s++) begin
          string tag;
          // loads
          issue(2'b00, 2'(sz), 1'(s), 1'b0, 16'h0, pats[p], ~pats[p]);
          if (sz == 3) tag = "R13 load";
          else if (sz == 2) tag = "R6 load";
          else if (s == 1 && sz == 0) tag = "R5 load";
          else if (s == 1) tag = "R4 load";
          else tag = "R3 load";
          check("R2 load wb_valid", 64'(wb_valid), 1);
          check("R2 load st_valid", 64'(st_valid), 0);
          check(tag, 64'(wb_data), 64'(exp_load(pats[p], 2'(sz), 1'(s))));
          // stores
          issue(2'b10, 2'(sz), 1'(s), 1'b0, 16'h0, pats[p], 32'h0);
          if (sz == 3) tag = "R13 store";
          else if (sz == 2) tag = "R9 store";
          else if (sz == 1) tag = "R10 store";
          else tag = "R11 store";
          if (s == 1) tag = {tag, " R12 signed flag"};
          check("R2 store st_valid", 64'(st_valid), 1);
          check("R2 store wb_valid", 64'(wb_valid), 0);
          check(tag, 64'(st_data), 64'(exp_store(pats[p], 2'(sz))));
          check({tag, " be"}, 64'(st_be), 64'((1 << (width_bits(2'(sz)) / 8)) - 1));
        end
      end
      // immediates
      for (int hi = 0; hi < 2; hi++) begin
        logic [15:0] iv;
        iv = pats[p][31:16] ^ pats[p][15:0];
        issue(2'b01, 2'b00, 1'b0, 1'(hi), iv, 32'h0, pats[p]);
        check("R2 imm wb_valid", 64'(wb_valid), 1);
        if (hi == 1)
          check("R8 imm high", 64'(wb_data), 64'((32'(iv) << 16) + (pats[p] % 32'h10000)));
        else
          check("R7 imm low", 64'(wb_data), 64'(32'(iv)));
      end
      if (p % 8 == 0) begin
        idle_check(1'b1, 2'b11);
        idle_check(1'b0, 2'b10);
        idle_check(1'b0, 2'b00);
      end
    end

    // two-step 32-bit constant build
    issue(2'b01, 2'b00, 1'b0, 1'b0, 16'h5678, 32'h0, 32'hDEAD_BEEF);
    check("R7 build step 1", 64'(wb_data), 64'h0000_5678);
    issue(2'b01, 2'b00, 1'b0, 1'b1, 16'h1234, 32'h0, 32'h0000_5678);
    check("R8 build step 2", 64'(wb_data), 64'h1234_5678);

    idle_check(1'b0, 2'b01);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule